// File: doc/BRIEF.md
# USB Host Bulk-OUT Transmit Endpoint

This block is the host-side control and status unit for one transmit endpoint that carries bulk OUT transfers. Software programs it through a small register port with the target device's function address, its endpoint number, the transfer type, the bus speed and the largest packet the endpoint accepts. Packet bytes are loaded one at a time into a transmit FIFO. The FIFO holds one packet, or two when double buffering is switched on. A packet becomes ready for transmission in one of two ways: software marks it ready, or the block marks it ready by itself once a full maximum-size packet has been loaded.

A downstream transaction engine sees a request line together with the addressing fields, the length, the DATA0/DATA1 toggle and a byte read port. It reports each outcome as a one-cycle pulse: packet sent, ACK received or NAK received. The block advances the toggle, retires acknowledged packets, raises an interrupt, and counts frames after a NAK against a programmable limit. When that limit is reached it halts the endpoint.

Register map (reg_addr): 0 function address [6:0]; 1 type register {speed[7:6], transfer type[5:4], target endpoint[3:0]}; 2 max packet size [10:0] with double-buffer enable at bit 15; 3 NAK limit code [4:0]; 4 control/status; 5 interrupt {pending bit 1, enable bit 0}.

Top module: `usb_host_txep`

## Requirements
- R1: After reset, every register reads 0, eng_req is 0 and irq is 0.
- R2: Registers 0 to 3 read back their written fields. Control bits 15 (auto-ready), 14, 13 (transmit FIFO mode), 12, 11 and 10 read back as written. eng_func_addr, eng_ep_num and eng_speed follow registers 0 and 1. eng_req is high only while a packet is ready, control bit 13 is 1 and type[5:4] is 2'b10 (bulk).
- R3: With control bit 15 set, loading the byte that brings the current buffer to the programmed max packet size sets packet-ready (control bit 0) on the next cycle. Fewer bytes leave it clear.
- R4: Writing 1 to control bit 0 marks the loaded bytes as a ready packet of any length, and eng_len shows that length.
- R5: An ACK for a ready packet clears packet-ready, makes the next buffer active and restarts the eng_rdata stream at that buffer's first byte. When the interrupt enable is 1 it also sets the pending bit and irq.
- R6: In normal toggle operation (control bit 11 = 0), the toggle (eng_toggle, control bit 8 on read) flips on each ACKed packet and does not change on a NAK or a sent pulse.
- R7: Writing control bit 6 clears the toggle to DATA0. Writing bit 9 loads the toggle from bit 8. Writing bit 8 without bit 9 leaves the toggle unchanged.
- R8: With control bit 11 set, the toggle flips on every sent pulse and does not change on an ACK.
- R9: Control bit 1 is 1 while any packet is held. Writing control bit 3 discards one packet. With double buffering on and both buffers ready, two flush writes are needed to empty the FIFO.
- R10: A byte written while every buffer is ready is dropped and sets the overrun flag (control bit 2). A later control write clears the flag.
- R11: After a NAK with no ACK since, a NAK limit code m (1 to 16) times out on frame tick number 2^(m-1). The timeout clears packet-ready and sets control bit 7. Code 0 never times out.
- R12: An ACK restarts the NAK frame count.
- R13: A timeout sets the pending bit when the interrupt enable is 1. Writing control bit 0 while halted clears the halt and makes the held packet ready again.
- R14: Writing 1 to interrupt bit 1 clears the pending bit and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| fifo_we | input | 1 | FIFO byte write strobe |
| fifo_wdata | input | 8 | FIFO byte |
| eng_req | output | 1 | Packet ready for the transaction engine |
| eng_func_addr | output | 7 | Target function address |
| eng_ep_num | output | 4 | Target endpoint number |
| eng_speed | output | 2 | Speed field |
| eng_len | output | 7 | Length of the active packet |
| eng_toggle | output | 1 | Current data toggle (0 = DATA0) |
| eng_rd | input | 1 | Advance the byte read pointer |
| eng_rdata | output | 8 | Byte of the active packet at the read pointer |
| eng_sent | input | 1 | Packet-sent pulse |
| eng_ack | input | 1 | ACK pulse |
| eng_nak | input | 1 | NAK pulse |
| frame_tick | input | 1 | One pulse per frame or microframe |
| irq | output | 1 | Endpoint interrupt |

## Verification
Every register write, byte load, engine pulse and frame tick takes effect at the clock edge that samples it, so each status bit, eng_req, eng_toggle, eng_len and irq is due one cycle later. reg_rdata and eng_rdata are combinational and follow the address or read pointer within the same cycle. The bench drives inputs on the falling edge and holds them for exactly one rising edge. It reads results shortly after the following falling edge, which is the first point where the updated state is visible. For the NAK limit, frame_tick is held for exactly 2^(m-1)-1 edges, the endpoint is confirmed still ready, and then one more edge must produce the timeout.

// File: rtl/txep_pkg.sv
package txep_pkg;
  localparam logic [2:0] ADR_FADDR  = 3'd0;
  localparam logic [2:0] ADR_TYPE   = 3'd1;
  localparam logic [2:0] ADR_MAXP   = 3'd2;
  localparam logic [2:0] ADR_NAKLIM = 3'd3;
  localparam logic [2:0] ADR_CTRL   = 3'd4;
  localparam logic [2:0] ADR_INTR   = 3'd5;

  localparam logic [1:0] XFER_BULK = 2'b10;

  // control register bit positions
  localparam int CB_AUTORDY = 15;
  localparam int CB_ISO     = 14;
  localparam int CB_TXMODE  = 13;
  localparam int CB_DMAEN   = 12;
  localparam int CB_FRCTOG  = 11;
  localparam int CB_DMAMODE = 10;
  localparam int CB_TOGWE   = 9;
  localparam int CB_TOGVAL  = 8;
  localparam int CB_NAKTO   = 7;
  localparam int CB_TOGCLR  = 6;
  localparam int CB_FLUSH   = 3;
  localparam int CB_OVERRUN = 2;
  localparam int CB_NONEMPTY = 1;
  localparam int CB_READY   = 0;

  localparam int FRAME_W    = 16;
  localparam int NAK_CODE_W = 5;

  // limit code m -> 2^(m-1) frames, 0 -> disabled
  function automatic logic [FRAME_W-1:0] nak_frames(input logic [NAK_CODE_W-1:0] code);
    logic [FRAME_W-1:0] one;
    one = FRAME_W'(1);
    if (code == '0) return '0;
    if (code >= NAK_CODE_W'(FRAME_W)) return one << (FRAME_W - 1);
    return one << (code - NAK_CODE_W'(1));
  endfunction

  // next buffer index in a one- or two-entry ring
  function automatic logic next_buf(input logic sel, input logic two);
    return two ? ~sel : 1'b0;
  endfunction
endpackage

// File: rtl/txep_buffers.sv
module txep_buffers import txep_pkg::*; #(
  parameter int BUF_BYTES = 64,
  parameter int MAXP_W    = 11,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int PTR_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbuf,
  input  logic              autoset,
  input  logic [MAXP_W-1:0] maxp,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              commit_req,
  input  logic              flush_req,
  input  logic              ack,
  input  logic              nak,
  input  logic              rd_en,
  output logic              held,
  output logic [CNT_W-1:0]  act_len,
  output logic [7:0]        rd_data,
  output logic              accept_evt,
  output logic              overrun_evt,
  output logic              commit_evt,
  output logic              pop_evt
);
  logic [7:0]       mem [2][BUF_BYTES];
  logic [CNT_W-1:0] cnt [2];
  logic [1:0]       npk;
  logic             wr_sel, act_sel;
  logic [PTR_W-1:0] rd_ptr;
  logic             full, room;
  logic [MAXP_W-1:0] next_len;

  assign full        = (npk == (dbuf ? 2'd2 : 2'd1));
  assign room        = (cnt[wr_sel] != CNT_W'(BUF_BYTES));
  assign accept_evt  = wr_en && !full && room;
  assign overrun_evt = wr_en && !accept_evt;
  assign next_len    = MAXP_W'(cnt[wr_sel]) + MAXP_W'(1);
  assign commit_evt  = (accept_evt && autoset && (next_len == maxp)) ||
                       (commit_req && !full);
  assign held        = (npk != 2'd0);
  assign pop_evt     = (ack || flush_req) && held;
  assign act_len     = cnt[act_sel];
  assign rd_data     = mem[act_sel][rd_ptr];

  always_ff @(posedge clk) begin
    if (accept_evt) mem[wr_sel][cnt[wr_sel][PTR_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      npk     <= 2'd0;
      wr_sel  <= 1'b0;
      act_sel <= 1'b0;
      rd_ptr  <= '0;
      cnt[0]  <= '0;
      cnt[1]  <= '0;
    end else begin
      if (commit_evt && !pop_evt)      npk <= npk + 2'd1;
      else if (pop_evt && !commit_evt) npk <= npk - 2'd1;
      if (commit_evt) wr_sel  <= next_buf(wr_sel, dbuf);
      if (pop_evt)    act_sel <= next_buf(act_sel, dbuf);
      for (int b = 0; b < 2; b++) begin
        if (accept_evt && wr_sel == 1'(b))             cnt[b] <= cnt[b] + CNT_W'(1);
        if (pop_evt && act_sel == 1'(b))               cnt[b] <= '0;
        if (flush_req && !held && wr_sel == 1'(b))     cnt[b] <= '0;
      end
      if (ack || nak || flush_req) rd_ptr <= '0;
      else if (rd_en && held)      rd_ptr <= rd_ptr + PTR_W'(1);
    end
  end
endmodule

// File: rtl/txep_toggle.sv
module txep_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_clr,
  input  logic cpu_load,
  input  logic cpu_val,
  input  logic force_mode,
  input  logic sent,
  input  logic acked,
  output logic tog
);
  logic auto_flip;
  assign auto_flip = force_mode ? sent : acked;

  always_ff @(posedge clk) begin
    if (!rst_n)         tog <= 1'b0;
    else if (cpu_clr)   tog <= 1'b0;
    else if (cpu_load)  tog <= cpu_val;
    else if (auto_flip) tog <= ~tog;
  end
endmodule

// File: rtl/txep_naktimer.sv
module txep_naktimer import txep_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NAK_CODE_W-1:0] code,
  input  logic                  nak,
  input  logic                  ack,
  input  logic                  clear,
  input  logic                  tick,
  output logic                  timeout_evt,
  output logic                  armed
);
  logic [FRAME_W-1:0] frames, limit;

  assign limit       = nak_frames(code);
  assign timeout_evt = armed && tick && !ack && !clear && (limit != '0) &&
                       ((frames + FRAME_W'(1)) >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || ack || clear || timeout_evt) begin
      armed  <= 1'b0;
      frames <= '0;
    end else begin
      if (nak && limit != '0) armed <= 1'b1;
      if (armed && tick)      frames <= frames + FRAME_W'(1);
    end
  end
endmodule

// File: rtl/usb_host_txep.sv
module usb_host_txep import txep_pkg::*; #(
  parameter int BUF_BYTES = 64,
  parameter int MAXP_W    = 11,
  localparam int LEN_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             fifo_we,
  input  logic [7:0]       fifo_wdata,
  output logic             eng_req,
  output logic [6:0]       eng_func_addr,
  output logic [3:0]       eng_ep_num,
  output logic [1:0]       eng_speed,
  output logic [LEN_W-1:0] eng_len,
  output logic             eng_toggle,
  input  logic             eng_rd,
  output logic [7:0]       eng_rdata,
  input  logic             eng_sent,
  input  logic             eng_ack,
  input  logic             eng_nak,
  input  logic             frame_tick,
  output logic             irq
);
  logic [6:0]            faddr_q;
  logic [7:0]            type_q;
  logic [MAXP_W-1:0]     maxp_q;
  logic                  dbuf_q;
  logic [NAK_CODE_W-1:0] nakcode_q;
  logic autoset_q, iso_q, mode_q, dmaen_q, frctog_q, dmamode_q;
  logic halt_q, ovr_q, nakto_q, ie_q, pend_q;

  // named internal events
  logic ctrl_wr, intr_wr, flush_evt, resume_evt, commit_req;
  logic tog_clr, tog_load, tog_cpu_wr;
  logic held, pkt_rdy, ack_pop, accept_evt, overrun_evt, commit_evt;
  logic timeout_evt, nak_armed, irq_set;

  assign ctrl_wr    = reg_we && (reg_addr == ADR_CTRL);
  assign intr_wr    = reg_we && (reg_addr == ADR_INTR);
  assign flush_evt  = ctrl_wr && reg_wdata[CB_FLUSH];
  assign resume_evt = ctrl_wr && reg_wdata[CB_READY] && halt_q;
  assign commit_req = ctrl_wr && reg_wdata[CB_READY] && !halt_q;
  assign tog_clr    = ctrl_wr && reg_wdata[CB_TOGCLR];
  assign tog_load   = ctrl_wr && reg_wdata[CB_TOGWE];
  assign tog_cpu_wr = tog_clr || tog_load;

  txep_buffers #(.BUF_BYTES(BUF_BYTES), .MAXP_W(MAXP_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .dbuf(dbuf_q), .autoset(autoset_q), .maxp(maxp_q),
    .wr_en(fifo_we), .wr_data(fifo_wdata), .commit_req(commit_req),
    .flush_req(flush_evt), .ack(eng_ack), .nak(eng_nak), .rd_en(eng_rd),
    .held(held), .act_len(eng_len), .rd_data(eng_rdata),
    .accept_evt(accept_evt), .overrun_evt(overrun_evt),
    .commit_evt(commit_evt), .pop_evt()
  );

  assign ack_pop = eng_ack && held;

  txep_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .cpu_clr(tog_clr), .cpu_load(tog_load),
    .cpu_val(reg_wdata[CB_TOGVAL]), .force_mode(frctog_q),
    .sent(eng_sent), .acked(ack_pop), .tog(eng_toggle)
  );

  txep_naktimer u_nak (
    .clk(clk), .rst_n(rst_n), .code(nakcode_q), .nak(eng_nak), .ack(ack_pop),
    .clear(flush_evt || resume_evt), .tick(frame_tick),
    .timeout_evt(timeout_evt), .armed(nak_armed)
  );

  assign pkt_rdy       = held && !halt_q;
  assign eng_req       = pkt_rdy && mode_q && (type_q[5:4] == XFER_BULK);
  assign eng_func_addr = faddr_q;
  assign eng_ep_num    = type_q[3:0];
  assign eng_speed     = type_q[7:6];
  assign irq_set       = ie_q && (ack_pop || timeout_evt);
  assign irq           = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      faddr_q <= '0; type_q <= '0; maxp_q <= '0; dbuf_q <= 1'b0; nakcode_q <= '0;
      autoset_q <= 1'b0; iso_q <= 1'b0; mode_q <= 1'b0;
      dmaen_q <= 1'b0; frctog_q <= 1'b0; dmamode_q <= 1'b0;
      halt_q <= 1'b0; ovr_q <= 1'b0; nakto_q <= 1'b0; ie_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          ADR_FADDR:  faddr_q   <= reg_wdata[6:0];
          ADR_TYPE:   type_q    <= reg_wdata[7:0];
          ADR_MAXP: begin
            maxp_q <= reg_wdata[MAXP_W-1:0];
            dbuf_q <= reg_wdata[15];
          end
          ADR_NAKLIM: nakcode_q <= reg_wdata[NAK_CODE_W-1:0];
          ADR_CTRL: begin
            autoset_q <= reg_wdata[CB_AUTORDY];
            iso_q     <= reg_wdata[CB_ISO];
            mode_q    <= reg_wdata[CB_TXMODE];
            dmaen_q   <= reg_wdata[CB_DMAEN];
            frctog_q  <= reg_wdata[CB_FRCTOG];
            dmamode_q <= reg_wdata[CB_DMAMODE];
          end
          ADR_INTR:   ie_q <= reg_wdata[0];
          default: ;
        endcase
      end
      if (timeout_evt)                    halt_q <= 1'b1;
      else if (resume_evt || flush_evt)   halt_q <= 1'b0;
      if (overrun_evt)  ovr_q <= 1'b1;
      else if (ctrl_wr) ovr_q <= 1'b0;
      if (timeout_evt)  nakto_q <= 1'b1;
      else if (ctrl_wr) nakto_q <= 1'b0;
      if (irq_set)                         pend_q <= 1'b1;
      else if (intr_wr && reg_wdata[1])    pend_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_FADDR:  reg_rdata = 16'(faddr_q);
      ADR_TYPE:   reg_rdata = 16'(type_q);
      ADR_MAXP: begin
        reg_rdata     = 16'(maxp_q);
        reg_rdata[15] = dbuf_q;
      end
      ADR_NAKLIM: reg_rdata = 16'(nakcode_q);
      ADR_CTRL: begin
        reg_rdata[CB_AUTORDY]  = autoset_q;
        reg_rdata[CB_ISO]      = iso_q;
        reg_rdata[CB_TXMODE]   = mode_q;
        reg_rdata[CB_DMAEN]    = dmaen_q;
        reg_rdata[CB_FRCTOG]   = frctog_q;
        reg_rdata[CB_DMAMODE]  = dmamode_q;
        reg_rdata[CB_TOGVAL]   = eng_toggle;
        reg_rdata[CB_NAKTO]    = nakto_q;
        reg_rdata[CB_OVERRUN]  = ovr_q;
        reg_rdata[CB_NONEMPTY] = held;
        reg_rdata[CB_READY]    = pkt_rdy;
      end
      ADR_INTR:   reg_rdata = {14'd0, pend_q, ie_q};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/txep_checker.sv
module txep_checker (
  input logic clk,
  input logic rst_n,
  input logic eng_sent,
  input logic frctog,
  input logic tog,
  input logic tog_cpu_wr,
  input logic ctrl_wr,
  input logic ack_pop,
  input logic overrun_evt,
  input logic ovr_flag,
  input logic timeout_evt,
  input logic pkt_rdy,
  input logic nakto_flag,
  input logic ie,
  input logic irq
);
  // R6: a normal ACK advances the toggle
  a_r6_ack_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pop && !frctog && !tog_cpu_wr) |=> (tog != $past(tog)));

  // R7: a control write without clear or load leaves the toggle alone
  a_r7_value_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !tog_cpu_wr && !ack_pop && !eng_sent) |=> $stable(tog));

  // R8: forced toggling ignores ACK
  a_r8_force_ignores_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (frctog && ack_pop && !eng_sent && !tog_cpu_wr) |=> $stable(tog));

  // R10: dropped byte raises the sticky flag
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> ovr_flag);

  // R11: timeout halts the endpoint and flags it
  a_r11_timeout_halts: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (!pkt_rdy && nakto_flag));

  // R5: acknowledged packet interrupts when enabled
  a_r5_ack_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pop && ie) |=> irq);

  // R13: timeout interrupts when enabled
  a_r13_timeout_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && ie) |=> irq);
endmodule

bind usb_host_txep txep_checker u_chk (
  .clk(clk), .rst_n(rst_n), .eng_sent(eng_sent), .frctog(frctog_q),
  .tog(eng_toggle), .tog_cpu_wr(tog_cpu_wr), .ctrl_wr(ctrl_wr),
  .ack_pop(ack_pop), .overrun_evt(overrun_evt), .ovr_flag(ovr_q),
  .timeout_evt(timeout_evt), .pkt_rdy(pkt_rdy), .nakto_flag(nakto_q),
  .ie(ie_q), .irq(irq)
);

// File: tb/usb_host_txep_bench.sv
module usb_host_txep_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        fifo_we = 1'b0;
  logic [7:0]  fifo_wdata = '0;
  logic        eng_req;
  logic [6:0]  eng_func_addr;
  logic [3:0]  eng_ep_num;
  logic [1:0]  eng_speed;
  logic [6:0]  eng_len;
  logic        eng_toggle;
  logic        eng_rd = 1'b0;
  logic [7:0]  eng_rdata;
  logic        eng_sent = 1'b0, eng_ack = 1'b0, eng_nak = 1'b0;
  logic        frame_tick = 1'b0;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  logic [15:0] cbase = '0;
  logic [15:0] rv;

  // {limit code, frames until timeout}
  localparam int NAKTAB [5][2] = '{'{1, 1}, '{2, 2}, '{3, 4}, '{6, 32}, '{16, 32768}};

  always #5 clk = ~clk;

  usb_host_txep u_usb_host_txep (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_we(fifo_we),
    .fifo_wdata(fifo_wdata), .eng_req(eng_req), .eng_func_addr(eng_func_addr),
    .eng_ep_num(eng_ep_num), .eng_speed(eng_speed), .eng_len(eng_len),
    .eng_toggle(eng_toggle), .eng_rd(eng_rd), .eng_rdata(eng_rdata),
    .eng_sent(eng_sent), .eng_ack(eng_ack), .eng_nak(eng_nak),
    .frame_tick(frame_tick), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ctrl(input logic [15:0] strobes);
    wr(3'd4, cbase | strobes);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); fifo_we = 1'b1; fifo_wdata = b;
    @(negedge clk); fifo_we = 1'b0;
  endtask

  task automatic pulse(input logic s, input logic a, input logic n, input logic r);
    @(negedge clk); eng_sent = s; eng_ack = a; eng_nak = n; eng_rd = r;
    @(negedge clk); eng_sent = 1'b0; eng_ack = 1'b0; eng_nak = 1'b0; eng_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); frame_tick = 1'b1;
      repeat (n) @(negedge clk);
      frame_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd4, rv); check("R1 ctrl", rv, 0);
    rd(3'd2, rv); check("R1 maxp", rv, 0);
    check("R1 eng_req", eng_req, 0);
    check("R1 irq", irq, 0);

    // R2 settings
    wr(3'd0, 16'h002A);
    wr(3'd1, 16'h0065);
    wr(3'd2, 16'h0004);
    rd(3'd1, rv); check("R2 type", rv, 16'h0065);
    check("R2 func addr", eng_func_addr, 7'h2A);
    check("R2 ep num", eng_ep_num, 4'h5);
    check("R2 speed", eng_speed, 2'b01);
    wr(3'd4, 16'hFC00);
    rd(3'd4, rv); check("R2 ctrl stored bits", rv, 16'hFC00);
    cbase = 16'hA000;
    ctrl(16'h0000);
    rd(3'd4, rv); check("R2 ctrl rewrite", rv, 16'hA000);

    // R3 auto-ready at max packet size 4
    push(8'h11); push(8'h22); push(8'h33);
    rd(3'd4, rv); check("R3 not ready at 3 bytes", rv[1:0], 2'b00);
    push(8'h44);
    rd(3'd4, rv); check("R3 ready at 4 bytes", rv[1:0], 2'b11);
    check("R3 eng_req", eng_req, 1);
    check("R4 eng_len", eng_len, 7'd4);
    check("R5 first byte", eng_rdata, 8'h11);
    pulse(0, 0, 0, 1);
    check("R5 second byte", eng_rdata, 8'h22);

    // R2 request gating on transfer type
    wr(3'd1, 16'h0045);
    check("R2 eng_req needs bulk", eng_req, 0);
    wr(3'd1, 16'h0065);
    check("R2 eng_req restored", eng_req, 1);

    // R5 / R6 ACK retires packet, toggles, interrupts
    wr(3'd5, 16'h0001);
    pulse(0, 1, 0, 0);
    rd(3'd4, rv); check("R5 ready cleared", rv[1:0], 2'b00);
    check("R5 irq", irq, 1);
    check("R6 toggle after ack", eng_toggle, 1);
    wr(3'd5, 16'h0003);
    check("R14 irq cleared", irq, 0);
    pulse(0, 0, 1, 0);
    check("R6 nak keeps toggle", eng_toggle, 1);
    pulse(1, 0, 0, 0);
    check("R6 sent keeps toggle", eng_toggle, 1);

    // R7 toggle writes
    ctrl(16'h0200);
    check("R7 load 0", eng_toggle, 0);
    ctrl(16'h0100);
    check("R7 value without enable ignored", eng_toggle, 0);
    ctrl(16'h0300);
    rd(3'd4, rv); check("R7 load 1 readback", rv[8], 1);
    ctrl(16'h0040);
    check("R7 clear", eng_toggle, 0);

    // R8 forced toggling
    cbase = 16'hA800; ctrl(16'h0000);
    pulse(1, 0, 0, 0);
    check("R8 sent flips", eng_toggle, 1);
    push(8'h01); push(8'h02); push(8'h03); push(8'h04);
    pulse(0, 1, 0, 0);
    check("R8 ack ignored", eng_toggle, 1);
    wr(3'd5, 16'h0003);
    cbase = 16'h2000; ctrl(16'h0000);

    // R4 software-marked short packet
    push(8'hA1); push(8'hA2); push(8'hA3);
    rd(3'd4, rv); check("R4 not ready before mark", rv[0], 0);
    ctrl(16'h0001);
    rd(3'd4, rv); check("R4 ready after mark", rv[0], 1);
    check("R4 short length", eng_len, 7'd3);
    pulse(0, 1, 0, 0);
    check("R6 toggle after second ack", eng_toggle, 0);
    wr(3'd5, 16'h0003);

    // R9 / R10 double buffering, max packet 2
    wr(3'd2, 16'h8002);
    cbase = 16'hA000; ctrl(16'h0000);
    push(8'h51); push(8'h52); push(8'h53); push(8'h54);
    push(8'h55);
    rd(3'd4, rv); check("R10 overrun with both ready", rv[2:0], 3'b111);
    pulse(0, 1, 0, 0);
    check("R5 next buffer first byte", eng_rdata, 8'h53);
    pulse(0, 0, 0, 1);
    check("R10 dropped byte absent", eng_rdata, 8'h54);
    ctrl(16'h0000);
    rd(3'd4, rv); check("R10 overrun cleared", rv[2], 0);
    push(8'h61); push(8'h62);
    ctrl(16'h0008);
    rd(3'd4, rv); check("R9 one flush leaves data", rv[1], 1);
    ctrl(16'h0008);
    rd(3'd4, rv); check("R9 second flush empties", rv[1], 0);
    wr(3'd5, 16'h0003);

    // R11 NAK limit table, single buffer
    wr(3'd2, 16'h0002);
    for (int i = 0; i < 5; i++) begin
      push(8'h70); push(8'h71);
      wr(3'd3, 16'(NAKTAB[i][0]));
      pulse(0, 0, 1, 0);
      ticks(NAKTAB[i][1] - 1);
      rd(3'd4, rv); check("R11 ready before limit", rv[0], 1);
      ticks(1);
      rd(3'd4, rv); check("R11 timeout at limit", {rv[7], rv[1], rv[0]}, 3'b110);
      check("R13 timeout irq", irq, 1);
      wr(3'd5, 16'h0003);
      ctrl(16'h0008);
    end

    // R11 code 0 disables
    push(8'h80); push(8'h81);
    wr(3'd3, 16'h0000);
    pulse(0, 0, 1, 0);
    ticks(300);
    rd(3'd4, rv); check("R11 code 0 never times out", rv[0], 1);

    // R13 resume after halt
    wr(3'd3, 16'h0002);
    pulse(0, 0, 1, 0);
    ticks(2);
    rd(3'd4, rv); check("R13 halted", rv[0], 0);
    ctrl(16'h0001);
    rd(3'd4, rv); check("R13 resumed", {rv[7], rv[1], rv[0]}, 3'b011);
    pulse(0, 1, 0, 0);

    // R12 ACK restarts the frame count (limit 4 frames)
    wr(3'd3, 16'h0003);
    push(8'h90); push(8'h91);
    pulse(0, 0, 1, 0);
    ticks(3);
    pulse(0, 1, 0, 0);
    push(8'h92); push(8'h93);
    pulse(0, 0, 1, 0);
    ticks(3);
    rd(3'd4, rv); check("R12 count restarted", rv[0], 1);
    ticks(1);
    rd(3'd4, rv); check("R12 timeout after fresh count", rv[0], 0);
    ctrl(16'h0008);
    wr(3'd5, 16'h0003);
    check("R14 final irq clear", irq, 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule